// File: doc/BRIEF.md
# Two-Pin Sequence Mode Switch Detector

This block decides whether an LED sink driver runs in normal display mode or in output-fault detection mode. It adds no pins. On every rising clock edge it records the levels of the two control inputs that the driver already has, the active-low output enable and the latch strobe. Both inputs keep their usual meaning for the datapath at all times. When the most recent five samples form the fixed sequence for the mode the driver is not in, the block changes mode on the edge that completes that sequence.

The enter sequence applies to both inputs. The output enable is high, low, high, high, high over five edges. The latch is high only on the fourth of those edges. The resume sequence uses the same output-enable steps, but the latch stays low on all five edges. The two requests must alternate. The block only looks for the sequence that leaves the current mode, so a repeated request of the same kind has no effect. Running a new detection pass therefore means resuming normal mode first and then entering detection mode again.

A one-cycle ready strobe follows entry into detection mode. It tells the serial datapath that the next rising edge is the first one on which serial input data is valid.

Top module: `mode_seq_detect`

## Requirements
- R1: While the external reset is low and for two rising edges after it is released, `detect_mode_o` and `data_ready_o` are 0. The sample history is empty, so no sequence can complete using samples taken before that point.
- R2: One (`oe_n_i`, `latch_i`) sample is taken on each rising edge once reset has been released. A sequence is recognised from five samples on consecutive edges, whatever came before them.
- R3: In normal mode (`detect_mode_o`=0), the block enters detection mode if five consecutive edges sample `oe_n_i` = 1,0,1,1,1 and `latch_i` = 0,0,0,1,0. `detect_mode_o` is 1 right after the fifth edge, and not earlier.
- R4: `data_ready_o` is 1 for exactly the one cycle that follows the edge completing an accepted enter sequence, and is 0 at all other times. So the sixth edge is the first on which serial input data may be sampled.
- R5: In detection mode, the block returns to normal mode if five consecutive edges sample `oe_n_i` = 1,0,1,1,1 with `latch_i` = 0 on all five. `detect_mode_o` is 0 right after the fifth edge.
- R6: An enter sequence applied in detection mode, or a resume sequence applied in normal mode, leaves `detect_mode_o` and `data_ready_o` unchanged.
- R7: The history is emptied on the edge that completes an accepted sequence. The next mode change therefore needs five fresh samples taken after that edge, and samples taken on or before it cannot complete a sequence.
- R8: A sequence that differs from the expected one in any single step causes no mode change.
- R9: A resume followed by a new enter puts the block back in detection mode, with a new ready strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock that also paces the serial data |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| oe_n_i | input | 1 | Active-low output enable, sampled as the first sequence input |
| latch_i | input | 1 | Latch strobe, sampled as the second sequence input |
| detect_mode_o | output | 1 | 1 while the driver is in fault detection mode |
| data_ready_o | output | 1 | One-cycle strobe: the next edge is the first valid serial input sample of detection mode |

## Verification
Faults in the internal state show up within the five edges of the next sequence attempt. A history that shifts wrongly or is not emptied makes the mode flip early, late, or on a sequence that overlaps the previous one. A wrong mode bit lets a repeated request of the same kind toggle the output. A misplaced ready strobe shows up in the cycle right after entry. The stimulus combines directed sequences, including overlapping and single-step-corrupted ones, with random mixes of valid sequences and noise.

// File: rtl/mode_seq_pkg.sv
package mode_seq_pkg;

  // One recorded edge: valid flag plus the two control pin levels.
  typedef struct packed {
    logic vld;
    logic oe_n;
    logic le;
  } pin_smp_t;

  localparam int unsigned SEQ_STEPS = 5;

  // Bit j holds the level expected on edge j+1 of a sequence.
  localparam logic [SEQ_STEPS-1:0] ENTER_OE_PAT  = 5'b11101;
  localparam logic [SEQ_STEPS-1:0] ENTER_LE_PAT  = 5'b01000;
  localparam logic [SEQ_STEPS-1:0] RESUME_OE_PAT = 5'b11101;
  localparam logic [SEQ_STEPS-1:0] RESUME_LE_PAT = 5'b00000;

endpackage

// File: rtl/ms_rst_sync.sv
module ms_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_sync = sync_q[1];

endmodule

// File: rtl/ms_history.sv
module ms_history
  import mode_seq_pkg::*;
#(
  parameter int unsigned DEPTH = SEQ_STEPS - 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 clr_i,
  input  pin_smp_t             smp_i,
  output pin_smp_t [DEPTH-1:0] hist_o
);

  // Index 0 is the oldest stored sample.
  pin_smp_t [DEPTH-1:0] hist_q;
  pin_smp_t [DEPTH-1:0] hist_d;

  always_comb begin
    hist_d = hist_q;
    if (clr_i) begin
      hist_d = '0;
    end else begin
      for (int j = 0; j < int'(DEPTH) - 1; j++) begin
        hist_d[j] = hist_q[j+1];
      end
      hist_d[DEPTH-1] = smp_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hist_q <= '0;
    else        hist_q <= hist_d;
  end

  assign hist_o = hist_q;

endmodule

// File: rtl/ms_matcher.sv
module ms_matcher
  import mode_seq_pkg::*;
#(
  parameter int unsigned   STEPS  = SEQ_STEPS,
  parameter logic [STEPS-1:0] OE_PAT = ENTER_OE_PAT,
  parameter logic [STEPS-1:0] LE_PAT = ENTER_LE_PAT
) (
  input  pin_smp_t [STEPS-2:0] hist_i,
  input  pin_smp_t             smp_i,
  output logic                 hit_o
);

  logic [STEPS-1:0] step_ok;

  for (genvar j = 0; j < STEPS; j++) begin : g_step
    pin_smp_t win;
    if (j < STEPS - 1) begin : g_stored
      assign win = hist_i[j];
    end else begin : g_live
      assign win = smp_i;
    end
    assign step_ok[j] = win.vld && (win.oe_n == OE_PAT[j]) && (win.le == LE_PAT[j]);
  end

  assign hit_o = &step_ok;

endmodule

// File: rtl/ms_mode_ctl.sv
module ms_mode_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic enter_hit_i,
  input  logic resume_hit_i,
  output logic detect_o,
  output logic ready_o,
  output logic clr_o
);

  logic det_q, det_d;
  logic rdy_q, rdy_d;
  logic enter_acc, resume_acc;

  always_comb begin
    enter_acc  = !det_q && enter_hit_i;
    resume_acc = det_q && resume_hit_i;
    det_d      = det_q;
    if (enter_acc)  det_d = 1'b1;
    if (resume_acc) det_d = 1'b0;
    rdy_d      = enter_acc;
    clr_o      = enter_acc || resume_acc;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      det_q <= 1'b0;
      rdy_q <= 1'b0;
    end else begin
      det_q <= det_d;
      rdy_q <= rdy_d;
    end
  end

  assign detect_o = det_q;
  assign ready_o  = rdy_q;

endmodule

// File: rtl/mode_seq_detect.sv
module mode_seq_detect
  import mode_seq_pkg::*;
#(
  parameter int unsigned      STEPS     = SEQ_STEPS,
  parameter logic [STEPS-1:0] ENTER_OE  = ENTER_OE_PAT,
  parameter logic [STEPS-1:0] ENTER_LE  = ENTER_LE_PAT,
  parameter logic [STEPS-1:0] RESUME_OE = RESUME_OE_PAT,
  parameter logic [STEPS-1:0] RESUME_LE = RESUME_LE_PAT
) (
  input  logic clk,
  input  logic rst_n,
  input  logic oe_n_i,
  input  logic latch_i,
  output logic detect_mode_o,
  output logic data_ready_o
);

  localparam int unsigned HIST_DEPTH = STEPS - 1;

  logic                      rst_n_int;
  pin_smp_t                  smp;
  pin_smp_t [HIST_DEPTH-1:0] hist;
  logic                      enter_hit, resume_hit, clr;

  ms_rst_sync u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_int)
  );

  assign smp = '{vld: 1'b1, oe_n: oe_n_i, le: latch_i};

  ms_history #(.DEPTH(HIST_DEPTH)) u_hist (
    .clk    (clk),
    .rst_n  (rst_n_int),
    .clr_i  (clr),
    .smp_i  (smp),
    .hist_o (hist)
  );

  ms_matcher #(.STEPS(STEPS), .OE_PAT(ENTER_OE), .LE_PAT(ENTER_LE)) u_enter_match (
    .hist_i (hist),
    .smp_i  (smp),
    .hit_o  (enter_hit)
  );

  ms_matcher #(.STEPS(STEPS), .OE_PAT(RESUME_OE), .LE_PAT(RESUME_LE)) u_resume_match (
    .hist_i (hist),
    .smp_i  (smp),
    .hit_o  (resume_hit)
  );

  ms_mode_ctl u_mode (
    .clk          (clk),
    .rst_n        (rst_n_int),
    .enter_hit_i  (enter_hit),
    .resume_hit_i (resume_hit),
    .detect_o     (detect_mode_o),
    .ready_o      (data_ready_o),
    .clr_o        (clr)
  );

endmodule

// File: rtl/mode_seq_chk.sv
module mode_seq_chk (
  input logic clk,
  input logic rst_n,
  input logic oe_n_i,
  input logic latch_i,
  input logic detect_mode_o,
  input logic data_ready_o
);

  logic       prev_det;
  logic [2:0] gap;

  // gap = edges since the last mode change (or since reset), saturating.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_det <= 1'b0;
      gap      <= 3'd0;
    end else begin
      prev_det <= detect_mode_o;
      if (detect_mode_o != prev_det) gap <= 3'd1;
      else if (gap != 3'd7)          gap <= gap + 3'd1;
    end
  end

  always @(posedge clk) begin
    if (!rst_n) AST_RESET_IDLE: assert (!detect_mode_o && !data_ready_o); // R1
  end

  AST_ENTER_LAST_STEPS: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(detect_mode_o) |-> ($past(oe_n_i) && !$past(latch_i) && $past(latch_i, 2) && $past(oe_n_i, 2))); // R3

  AST_READY_ON_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(detect_mode_o) |-> data_ready_o); // R4

  AST_READY_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    data_ready_o |=> !data_ready_o); // R4

  AST_READY_IN_DETECT: assert property (@(posedge clk) disable iff (!rst_n)
    data_ready_o |-> detect_mode_o); // R4

  AST_RESUME_LATCH_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(detect_mode_o) |-> (!$past(latch_i) && !$past(latch_i, 2) && $past(oe_n_i))); // R5

  AST_NO_OVERLAP: assert property (@(posedge clk) disable iff (!rst_n)
    (detect_mode_o != prev_det) |-> (gap >= 3'd5)); // R7

endmodule

bind mode_seq_detect mode_seq_chk u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .oe_n_i        (oe_n_i),
  .latch_i       (latch_i),
  .detect_mode_o (detect_mode_o),
  .data_ready_o  (data_ready_o)
);

// File: tb/mode_seq_detect_tb.sv
module mode_seq_detect_tb;

  logic clk = 1'b0;
  logic rst_n;
  logic oe_n_i;
  logic latch_i;
  logic detect_mode_o;
  logic data_ready_o;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  // Reference state from the requirements
  logic [3:0] m_v, m_oe, m_le;  // index 0 oldest
  logic       m_det, m_rdy;

  localparam logic [4:0] EN_OE = 5'b11101;
  localparam logic [4:0] EN_LE = 5'b01000;
  localparam logic [4:0] RS_OE = 5'b11101;
  localparam logic [4:0] RS_LE = 5'b00000;

  always #5 clk = ~clk;

  mode_seq_detect u_dut (
    .clk           (clk),
    .rst_n         (rst_n),
    .oe_n_i        (oe_n_i),
    .latch_i       (latch_i),
    .detect_mode_o (detect_mode_o),
    .data_ready_o  (data_ready_o)
  );

  function automatic bit seq_hit(input logic [4:0] po, input logic [4:0] pl,
                                 input logic co, input logic cl);
    bit ok = 1'b1;
    for (int j = 0; j < 4; j++) begin
      if (!m_v[j] || m_oe[j] != po[j] || m_le[j] != pl[j]) ok = 1'b0;
    end
    if (co != po[4] || cl != pl[4]) ok = 1'b0;
    return ok;
  endfunction

  task automatic model_edge(input logic co, input logic cl);
    bit en, rs;
    en = !m_det && seq_hit(EN_OE, EN_LE, co, cl);
    rs = m_det && seq_hit(RS_OE, RS_LE, co, cl);
    m_rdy = en;
    if (en) m_det = 1'b1;
    if (rs) m_det = 1'b0;
    if (en || rs) begin
      m_v = '0; m_oe = '0; m_le = '0;
    end else begin
      m_v  = {1'b1, m_v[3:1]};
      m_oe = {co, m_oe[3:1]};
      m_le = {cl, m_le[3:1]};
    end
  endtask

  task automatic check(input string req);
    n_chk++;
    if (detect_mode_o !== m_det || data_ready_o !== m_rdy) begin
      n_fail++;
      $display("FAIL %s: detect=%0b ready=%0b expected detect=%0b ready=%0b",
               req, detect_mode_o, data_ready_o, m_det, m_rdy);
    end
  endtask

  task automatic cyc(input logic co, input logic cl, input string req);
    @(negedge clk);
    oe_n_i  = co;
    latch_i = cl;
    @(posedge clk);
    model_edge(co, cl);
    #1;
    check(req);
  endtask

  task automatic send(input logic [4:0] po, input logic [4:0] pl, input string req);
    for (int j = 0; j < 5; j++) cyc(po[j], pl[j], req);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    #2_000_000;
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: run did not end, actual=timeout expected=finish");
    finish_run();
  end

  initial begin
    void'($urandom(32'h5eed_0042));
    m_v = '0; m_oe = '0; m_le = '0; m_det = 1'b0; m_rdy = 1'b0;
    rst_n = 1'b0; oe_n_i = 1'b0; latch_i = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    check("R1");                         // during reset
    @(negedge clk);
    rst_n = 1'b1;
    // idle sample (0,1) matches no step; internal reset still active
    repeat (2) begin
      @(posedge clk);
      #1;
      check("R1");
    end

    // R3/R4: entry from normal mode
    send(EN_OE, EN_LE, "R3");
    cyc(1'b0, 1'b1, "R4");               // strobe gone after one cycle
    // R6: enter sequence again while in detection mode
    send(EN_OE, EN_LE, "R6");
    // R5: resume
    send(RS_OE, RS_LE, "R5");
    // R6: resume again while in normal mode
    send(RS_OE, RS_LE, "R6");
    // R8: each single-step corruption of the enter sequence
    for (int k = 0; k < 5; k++) begin
      send(EN_OE, EN_LE ^ (5'b1 << k), "R8");
      cyc(1'b0, 1'b1, "R8");
      send(EN_OE ^ (5'b1 << k), EN_LE, "R8");
      cyc(1'b0, 1'b1, "R8");
    end
    // R7: enter, then only steps 2..5 of resume; the last enter sample
    // would serve as step 1 if the history were not cleared
    send(EN_OE, EN_LE, "R7");
    for (int j = 1; j < 5; j++) cyc(RS_OE[j], RS_LE[j], "R7");
    cyc(1'b0, 1'b1, "R7");
    // R9: resume then re-enter
    send(RS_OE, RS_LE, "R9");
    send(EN_OE, EN_LE, "R9");
    send(RS_OE, RS_LE, "R9");
    // R2: noise prefix then a sequence completes through the sliding window
    cyc(1'b1, 1'b0, "R2");
    cyc(1'b1, 1'b0, "R2");
    send(EN_OE, EN_LE, "R2");
    send(RS_OE, RS_LE, "R2");

    // Random mix of valid sequences, corrupted ones and noise
    for (int it = 0; it < 600; it++) begin
      int unsigned sel = $urandom_range(0, 9);
      if (sel < 3)      send(EN_OE, EN_LE, "R3");
      else if (sel < 5) send(RS_OE, RS_LE, "R5");
      else if (sel < 7) send(EN_OE, EN_LE ^ (5'b1 << $urandom_range(0, 4)), "R8");
      else              cyc(1'($urandom), 1'($urandom), "R2");
    end

    finish_run();
  end

endmodule